// File: doc/BRIEF.md
# Per-CPU Interrupt Mailbox

This block takes interrupt messages arriving from an external bus and parks each one in a mailbox owned by the message's target CPU. A message names its target CPU and a 5-bit source ID, and carries two 64-bit data words. Each CPU has one mailbox slot, guarded by a busy flag. While a CPU's flag is set, any new message for that CPU is refused at once and the sender must retry. A free slot accepts the message. The slot then stores the message, sets its busy flag and raises an interrupt post toward the target CPU. The post carries a single interrupt vector that all CPUs share.

Software reaches the mailboxes through a small register window. An indexed view lets any agent read any CPU's data words and status. A self view resolves to the mailbox of the CPU that issued the access, which is identified by the requester ID that comes with the access. Software frees a slot by writing its status register with the busy bit clear. The shared vector register is writable and readable in the same window.

Top module: `ixm_mailbox`

## Requirements
- R1: After reset every busy flag, source ID, stored data word and the shared vector read as zero, and `post_valid` is low.
- R2: `msg_ready` is combinational on the current cycle: it is 1 exactly when `msg_cpu` is below NUM_CPU and that CPU's busy flag is clear. A refused message (valid while not ready) changes no stored state and produces no post.
- R3: An accepted message (`msg_valid` and `msg_ready`) sets the target's busy flag and stores its source ID and both data words at the next clock edge.
- R4: One cycle after an accept, `post_valid` is 1 for exactly one cycle, with `post_cpu` equal to the accepted target and `post_vec` equal to the shared vector as it stood in the accept cycle.
- R5: A write to byte offset 0x000 loads the shared vector from `reg_wdata[5:0]`. A read of 0x000 returns the vector zero-extended.
- R6: The indexed data registers read CPU n's data word 0 at 0x100+8n and data word 1 at 0x200+8n, for n below NUM_CPU. Writes to them have no effect.
- R7: The status register at 0x300+8n reads busy in bit 5 and the source ID in bits 4:0, with all other bits zero.
- R8: A write to a status register loads the busy flag from `reg_wdata[5]`. All other written bits are ignored, and the stored source ID is kept.
- R9: The self registers at 0x400 (data word 0), 0x408 (data word 1) and 0x410 (status, readable and writable as in R7/R8) act on the mailbox of CPU `reg_req_id`. They act as unmapped when `reg_req_id` is NUM_CPU or above.
- R10: Address bits 2:0 are ignored. Any other offset, or an index at or above NUM_CPU, reads zero, and a write to it changes nothing.
- R11: When a message is accepted for a CPU in the same cycle as a status write to that CPU, the data and source are stored, and the busy flag takes the written bit 5.
- R12: `reg_rdata` is zero whenever `reg_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | Incoming message strobe |
| msg_cpu | input | 5 | Target CPU of the message |
| msg_src | input | 5 | Source ID of the message |
| msg_d0 | input | 64 | Message data word 0 |
| msg_d1 | input | 64 | Message data word 1 |
| msg_ready | output | 1 | Accept (1) or refuse (0) answer, same cycle |
| post_valid | output | 1 | Interrupt post strobe |
| post_cpu | output | 5 | CPU the post is for |
| post_vec | output | 6 | Vector carried by the post |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_req_id | input | 5 | CPU issuing the register access |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data |

## Verification
The assertions assume the sender holds no expectations of `msg_ready` beyond the current cycle, and that a status write is the only other thing that may touch a busy flag. In the rules for busy flags and posts, the register write strobe therefore appears as an explicit exception. The stimulus drives every input away from the clock edge. It sends messages to targets outside the CPU range and makes accesses to unmapped and out-of-range offsets on purpose. It also frees slots often enough through random status writes that accepts and refusals both keep occurring.

// File: rtl/ixm_pkg.sv
package ixm_pkg;

    // Kind of register selected by a decoded access
    typedef enum logic [2:0] {
        RK_NONE  = 3'd0,
        RK_VEC   = 3'd1,
        RK_DATA0 = 3'd2,
        RK_DATA1 = 3'd3,
        RK_STAT  = 3'd4
    } reg_kind_e;

    // Bit position of the busy flag inside a status word
    localparam int STAT_BUSY_BIT = 5;

    // Register groups, taken from address bits 10:8
    localparam logic [2:0] GRP_VEC  = 3'd0;
    localparam logic [2:0] GRP_D0   = 3'd1;
    localparam logic [2:0] GRP_D1   = 3'd2;
    localparam logic [2:0] GRP_STAT = 3'd3;
    localparam logic [2:0] GRP_SELF = 3'd4;

endpackage

// File: rtl/ixm_decode.sv
module ixm_decode
    import ixm_pkg::*;
#(
    parameter int NUM_CPU  = 8,
    parameter int ADDR_W   = 12,
    parameter int CPU_ID_W = 5
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic [CPU_ID_W-1:0] req_id,
    output reg_kind_e           kind,
    output logic [CPU_ID_W-1:0] tgt
);

    localparam logic [5:0]        IDX_LIM = 6'(NUM_CPU);
    localparam logic [CPU_ID_W:0] CPU_LIM = (CPU_ID_W + 1)'(NUM_CPU);

    logic [4:0] idx;
    logic [2:0] grp;
    logic       upper;
    logic       idx_ok;
    logic       req_ok;

    assign idx    = addr[7:3];
    assign grp    = addr[10:8];
    assign upper  = |addr[ADDR_W-1:11];
    assign idx_ok = {1'b0, idx} < IDX_LIM;
    assign req_ok = {1'b0, req_id} < CPU_LIM;

    always_comb begin
        kind = RK_NONE;
        tgt  = CPU_ID_W'(idx);
        if (!upper) begin
            case (grp)
                GRP_VEC:  if (idx == 5'd0) kind = RK_VEC;
                GRP_D0:   if (idx_ok) kind = RK_DATA0;
                GRP_D1:   if (idx_ok) kind = RK_DATA1;
                GRP_STAT: if (idx_ok) kind = RK_STAT;
                GRP_SELF: begin
                    tgt = req_id;
                    if (req_ok) begin
                        case (idx)
                            5'd0:    kind = RK_DATA0;
                            5'd1:    kind = RK_DATA1;
                            5'd2:    kind = RK_STAT;
                            default: kind = RK_NONE;
                        endcase
                    end
                end
                default: kind = RK_NONE;
            endcase
        end
    end

endmodule

// File: rtl/ixm_slot.sv
module ixm_slot #(
    parameter int DATA_W = 64,
    parameter int SRC_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [SRC_W-1:0]  src_in,
    input  logic [DATA_W-1:0] d0_in,
    input  logic [DATA_W-1:0] d1_in,
    input  logic              busy_we,
    input  logic              busy_wv,
    output logic              busy,
    output logic [SRC_W-1:0]  src,
    output logic [DATA_W-1:0] d0,
    output logic [DATA_W-1:0] d1
);

    typedef struct packed {
        logic              busy;
        logic [SRC_W-1:0]  src;
        logic [DATA_W-1:0] d0;
        logic [DATA_W-1:0] d1;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (take) begin
            slot_d.busy = 1'b1;
            slot_d.src  = src_in;
            slot_d.d0   = d0_in;
            slot_d.d1   = d1_in;
        end
        // a software status write has the last word on the flag
        if (busy_we) begin
            slot_d.busy = busy_wv;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign busy = slot_q.busy;
    assign src  = slot_q.src;
    assign d0   = slot_q.d0;
    assign d1   = slot_q.d1;

endmodule

// File: rtl/ixm_rdmux.sv
module ixm_rdmux
    import ixm_pkg::*;
#(
    parameter int NUM_CPU  = 8,
    parameter int DATA_W   = 64,
    parameter int SRC_W    = 5,
    parameter int VEC_W    = 6,
    parameter int CPU_ID_W = 5
) (
    input  reg_kind_e           kind,
    input  logic [CPU_ID_W-1:0] tgt,
    input  logic [NUM_CPU-1:0]  busy_vec,
    input  logic [SRC_W-1:0]    src_a [NUM_CPU],
    input  logic [DATA_W-1:0]   d0_a  [NUM_CPU],
    input  logic [DATA_W-1:0]   d1_a  [NUM_CPU],
    input  logic [VEC_W-1:0]    vec,
    output logic [DATA_W-1:0]   rdata
);

    localparam int CPU_W = $clog2(NUM_CPU);

    logic [CPU_W-1:0] sel;

    assign sel = tgt[CPU_W-1:0];

    always_comb begin
        rdata = '0;
        case (kind)
            RK_VEC:   rdata[VEC_W-1:0] = vec;
            RK_DATA0: rdata = d0_a[sel];
            RK_DATA1: rdata = d1_a[sel];
            RK_STAT: begin
                rdata[SRC_W-1:0]     = src_a[sel];
                rdata[STAT_BUSY_BIT] = busy_vec[sel];
            end
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/ixm_mailbox.sv
module ixm_mailbox
    import ixm_pkg::*;
#(
    parameter int NUM_CPU  = 8,
    parameter int DATA_W   = 64,
    parameter int SRC_W    = 5,
    parameter int VEC_W    = 6,
    parameter int CPU_ID_W = 5,
    parameter int ADDR_W   = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                msg_valid,
    input  logic [CPU_ID_W-1:0] msg_cpu,
    input  logic [SRC_W-1:0]    msg_src,
    input  logic [DATA_W-1:0]   msg_d0,
    input  logic [DATA_W-1:0]   msg_d1,
    output logic                msg_ready,
    output logic                post_valid,
    output logic [CPU_ID_W-1:0] post_cpu,
    output logic [VEC_W-1:0]    post_vec,
    input  logic                reg_rd,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [CPU_ID_W-1:0] reg_req_id,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata
);

    localparam int                CPU_W   = $clog2(NUM_CPU);
    localparam logic [CPU_ID_W:0] CPU_LIM = (CPU_ID_W + 1)'(NUM_CPU);

    typedef struct packed {
        logic [VEC_W-1:0]    vec;
        logic                pv;
        logic [CPU_ID_W-1:0] pc;
        logic [VEC_W-1:0]    pvec;
    } top_t;

    top_t st_d, st_q;

    logic [NUM_CPU-1:0]  busy_vec;
    logic [NUM_CPU-1:0]  take;
    logic [NUM_CPU-1:0]  stat_we;
    logic [SRC_W-1:0]    src_a [NUM_CPU];
    logic [DATA_W-1:0]   d0_a  [NUM_CPU];
    logic [DATA_W-1:0]   d1_a  [NUM_CPU];
    reg_kind_e           kind;
    logic [CPU_ID_W-1:0] tgt;
    logic [DATA_W-1:0]   mux_rdata;
    logic                cpu_ok;
    logic                accept;

    ixm_decode #(
        .NUM_CPU  (NUM_CPU),
        .ADDR_W   (ADDR_W),
        .CPU_ID_W (CPU_ID_W)
    ) u_dec (
        .addr   (reg_addr),
        .req_id (reg_req_id),
        .kind   (kind),
        .tgt    (tgt)
    );

    // accept/refuse answer, same cycle as the strobe
    assign cpu_ok    = {1'b0, msg_cpu} < CPU_LIM;
    assign msg_ready = cpu_ok && !busy_vec[msg_cpu[CPU_W-1:0]];
    assign accept    = msg_valid && msg_ready;

    for (genvar g = 0; g < NUM_CPU; g++) begin : g_slot
        assign take[g]    = accept && (msg_cpu == CPU_ID_W'(g));
        assign stat_we[g] = reg_wr && (kind == RK_STAT) && (tgt == CPU_ID_W'(g));

        ixm_slot #(
            .DATA_W (DATA_W),
            .SRC_W  (SRC_W)
        ) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .take    (take[g]),
            .src_in  (msg_src),
            .d0_in   (msg_d0),
            .d1_in   (msg_d1),
            .busy_we (stat_we[g]),
            .busy_wv (reg_wdata[STAT_BUSY_BIT]),
            .busy    (busy_vec[g]),
            .src     (src_a[g]),
            .d0      (d0_a[g]),
            .d1      (d1_a[g])
        );
    end

    ixm_rdmux #(
        .NUM_CPU  (NUM_CPU),
        .DATA_W   (DATA_W),
        .SRC_W    (SRC_W),
        .VEC_W    (VEC_W),
        .CPU_ID_W (CPU_ID_W)
    ) u_rd (
        .kind     (kind),
        .tgt      (tgt),
        .busy_vec (busy_vec),
        .src_a    (src_a),
        .d0_a     (d0_a),
        .d1_a     (d1_a),
        .vec      (st_q.vec),
        .rdata    (mux_rdata)
    );

    always_comb begin
        st_d    = st_q;
        st_d.pv = accept;
        if (accept) begin
            st_d.pc   = msg_cpu;
            st_d.pvec = st_q.vec;
        end
        if (reg_wr && (kind == RK_VEC)) begin
            st_d.vec = reg_wdata[VEC_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign post_valid = st_q.pv;
    assign post_cpu   = st_q.pc;
    assign post_vec   = st_q.pvec;
    assign reg_rdata  = reg_rd ? mux_rdata : '0;

endmodule

// File: rtl/ixm_chk.sv
module ixm_chk #(
    parameter int NUM_CPU  = 8,
    parameter int VEC_W    = 6,
    parameter int CPU_ID_W = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic                msg_valid,
    input logic                msg_ready,
    input logic [CPU_ID_W-1:0] msg_cpu,
    input logic                post_valid,
    input logic [CPU_ID_W-1:0] post_cpu,
    input logic [VEC_W-1:0]    post_vec,
    input logic                reg_wr,
    input logic [NUM_CPU-1:0]  busy_vec,
    input logic [VEC_W-1:0]    vec_now
);

    localparam int                CPU_W   = $clog2(NUM_CPU);
    localparam logic [CPU_ID_W:0] CPU_LIM = (CPU_ID_W + 1)'(NUM_CPU);

    logic             in_range;
    logic [CPU_W-1:0] idx;

    assign in_range = {1'b0, msg_cpu} < CPU_LIM;
    assign idx      = msg_cpu[CPU_W-1:0];

    p_refuse_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_range && busy_vec[idx]) |-> !msg_ready);

    p_refuse_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_range |-> !msg_ready);

    p_accept_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_ready && !reg_wr) |=> busy_vec[$past(idx)]);

    p_post_fields_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_ready) |=>
            (post_valid && post_cpu == $past(msg_cpu) && post_vec == $past(vec_now)));

    p_post_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        post_valid |-> $past(msg_valid && msg_ready));

    p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr && !(msg_valid && msg_ready)) |=> $stable(busy_vec));

endmodule

bind ixm_mailbox ixm_chk #(
    .NUM_CPU  (NUM_CPU),
    .VEC_W    (VEC_W),
    .CPU_ID_W (CPU_ID_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .msg_valid  (msg_valid),
    .msg_ready  (msg_ready),
    .msg_cpu    (msg_cpu),
    .post_valid (post_valid),
    .post_cpu   (post_cpu),
    .post_vec   (post_vec),
    .reg_wr     (reg_wr),
    .busy_vec   (busy_vec),
    .vec_now    (st_q.vec)
);

// File: tb/sim_ixm_mailbox.sv
module sim_ixm_mailbox;

    localparam int CLK_PERIOD = 10;
    localparam int NCPU       = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        msg_valid;
    logic [4:0]  msg_cpu;
    logic [4:0]  msg_src;
    logic [63:0] msg_d0, msg_d1;
    logic        msg_ready;
    logic        post_valid;
    logic [4:0]  post_cpu;
    logic [5:0]  post_vec;
    logic        reg_rd, reg_wr;
    logic [11:0] reg_addr;
    logic [4:0]  reg_req_id;
    logic [63:0] reg_wdata, reg_rdata;

    int checks = 0;
    int fails  = 0;

    // reference model
    logic        m_busy [NCPU];
    logic [4:0]  m_src  [NCPU];
    logic [63:0] m_d0   [NCPU];
    logic [63:0] m_d1   [NCPU];
    logic [5:0]  m_vec;
    logic        e_pv;
    logic [4:0]  e_pc;
    logic [5:0]  e_pvec;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ixm_mailbox u0 (
        .clk(clk), .rst_n(rst_n),
        .msg_valid(msg_valid), .msg_cpu(msg_cpu), .msg_src(msg_src),
        .msg_d0(msg_d0), .msg_d1(msg_d1), .msg_ready(msg_ready),
        .post_valid(post_valid), .post_cpu(post_cpu), .post_vec(post_vec),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_req_id(reg_req_id), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // 0 none, 1 vector, 2 data0, 3 data1, 4 status; tgt gives the CPU
    function automatic int bdec(input logic [11:0] a, input logic [4:0] rq, output int tgt);
        int g = int'(a[10:8]);
        int i = int'(a[7:3]);
        tgt = i;
        if (a[11]) return 0;
        if (g == 0) return (i == 0) ? 1 : 0;
        if (g >= 1 && g <= 3) return (i < NCPU) ? g + 1 : 0;
        if (g == 4) begin
            tgt = int'(rq);
            if (tgt >= NCPU || i > 2) return 0;
            return i + 2;
        end
        return 0;
    endfunction

    function automatic logic [63:0] exp_rd(input logic [11:0] a, input logic [4:0] rq);
        int t;
        int k = bdec(a, rq, t);
        case (k)
            1: return {58'd0, m_vec};
            2: return m_d0[t];
            3: return m_d1[t];
            4: return {58'd0, m_busy[t], m_src[t]};
            default: return 64'd0;
        endcase
    endfunction

    function automatic string rd_tag(input logic [11:0] a, input logic [4:0] rq);
        int t;
        int k = bdec(a, rq, t);
        if (a[10:8] == 3'd4 && k != 0) return "R9";
        case (k)
            1: return "R5";
            2, 3: return "R6";
            4: return "R7";
            default: return "R10";
        endcase
    endfunction

    function automatic logic exp_ready(input logic [4:0] c);
        return (int'(c) < NCPU) && !m_busy[int'(c)];
    endfunction

    task automatic idle_inputs();
        msg_valid = 0; msg_cpu = 0; msg_src = 0; msg_d0 = 0; msg_d1 = 0;
        reg_rd = 0; reg_wr = 0; reg_addr = 0; reg_req_id = 0; reg_wdata = 0;
    endtask

    // inputs are already set; check, clock, update model, check post
    task automatic cycle();
        int t, k;
        logic acc;
        #1;
        chk(msg_ready == exp_ready(msg_cpu), "R2 ready", 64'(msg_ready), 64'(exp_ready(msg_cpu)));
        if (reg_rd)
            chk(reg_rdata == exp_rd(reg_addr, reg_req_id), rd_tag(reg_addr, reg_req_id),
                reg_rdata, exp_rd(reg_addr, reg_req_id));
        else
            chk(reg_rdata == 64'd0, "R12 idle rdata", reg_rdata, 64'd0);
        acc  = msg_valid && exp_ready(msg_cpu);
        e_pv = acc;
        if (acc) begin
            e_pc   = msg_cpu;
            e_pvec = m_vec;
            m_busy[int'(msg_cpu)] = 1'b1;
            m_src[int'(msg_cpu)]  = msg_src;
            m_d0[int'(msg_cpu)]   = msg_d0;
            m_d1[int'(msg_cpu)]   = msg_d1;
        end
        if (reg_wr) begin
            k = bdec(reg_addr, reg_req_id, t);
            if (k == 1) m_vec = reg_wdata[5:0];
            if (k == 4) m_busy[t] = reg_wdata[5];
        end
        @(posedge clk);
        #1;
        chk(post_valid == e_pv, "R4 post_valid", 64'(post_valid), 64'(e_pv));
        if (e_pv) begin
            chk(post_cpu == e_pc, "R4 post_cpu", 64'(post_cpu), 64'(e_pc));
            chk(post_vec == e_pvec, "R4 post_vec", 64'(post_vec), 64'(e_pvec));
        end
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic send(input logic [4:0] c, input logic [4:0] s, input logic [63:0] a, input logic [63:0] b);
        msg_valid = 1; msg_cpu = c; msg_src = s; msg_d0 = a; msg_d1 = b;
    endtask

    task automatic peek(input logic [11:0] a, input logic [4:0] rq, input logic [63:0] e, input string tag);
        reg_rd = 1; reg_addr = a; reg_req_id = rq;
        #1;
        chk(reg_rdata == e, tag, reg_rdata, e);
        cycle();
    endtask

    task automatic poke(input logic [11:0] a, input logic [4:0] rq, input logic [63:0] w);
        reg_wr = 1; reg_addr = a; reg_req_id = rq; reg_wdata = w;
        cycle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int seed;
        idle_inputs();
        rst_n = 0;
        for (int i = 0; i < NCPU; i++) begin
            m_busy[i] = 0; m_src[i] = 0; m_d0[i] = 0; m_d1[i] = 0;
        end
        m_vec = 0; e_pv = 0; e_pc = 0; e_pvec = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk(post_valid == 1'b0, "R1 post_valid", 64'(post_valid), 0);
        peek(12'h000, 5'd0, 64'd0, "R1 vector");
        peek(12'h328, 5'd0, 64'd0, "R1 status");
        peek(12'h138, 5'd0, 64'd0, "R1 data0");
        // R5 vector write keeps bits 5:0 only
        poke(12'h000, 5'd0, 64'hFFFF_FFFF_FFFF_FFEA);
        peek(12'h000, 5'd0, 64'h2A, "R5 vector readback");
        // R3 accept then R7 status and R6 data readback
        send(5'd3, 5'h13, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888);
        #1;
        chk(msg_ready == 1'b1, "R2 free slot ready", 64'(msg_ready), 1);
        cycle();
        peek(12'h318, 5'd0, 64'h33, "R3 R7 busy and source");
        peek(12'h118, 5'd0, 64'h1111_2222_3333_4444, "R6 data0");
        peek(12'h21D, 5'd0, 64'h5555_6666_7777_8888, "R6 data1 low bits ignored");
        // R2 refused message leaves storage alone
        send(5'd3, 5'h07, 64'hDEAD, 64'hBEEF);
        #1;
        chk(msg_ready == 1'b0, "R2 busy refuse", 64'(msg_ready), 0);
        cycle();
        peek(12'h118, 5'd0, 64'h1111_2222_3333_4444, "R2 data kept");
        peek(12'h318, 5'd0, 64'h33, "R2 source kept");
        // R9 self view
        peek(12'h400, 5'd3, 64'h1111_2222_3333_4444, "R9 self data0");
        peek(12'h408, 5'd3, 64'h5555_6666_7777_8888, "R9 self data1");
        peek(12'h410, 5'd3, 64'h33, "R9 self status");
        peek(12'h400, 5'd9, 64'd0, "R9 self out of range");
        // R8 free through self status; source kept; other bits ignored
        poke(12'h410, 5'd3, 64'hFFFF_FFFF_FFFF_FFDF);
        peek(12'h318, 5'd0, 64'h13, "R8 freed source kept");
        poke(12'h328, 5'd0, 64'h20);
        peek(12'h328, 5'd0, 64'h20, "R8 set busy by write");
        // R10 unmapped / out of range
        send(5'd9, 5'h01, 64'h1, 64'h2);
        #1;
        chk(msg_ready == 1'b0, "R2 out of range cpu", 64'(msg_ready), 0);
        cycle();
        peek(12'h148, 5'd0, 64'd0, "R10 index out of range");
        poke(12'h500, 5'd0, 64'hFFFF_FFFF_FFFF_FFFF);
        poke(12'h008, 5'd0, 64'h3F);
        peek(12'h000, 5'd0, 64'h2A, "R10 vector untouched");
        // R6 data registers are read-only
        poke(12'h118, 5'd0, 64'h0);
        peek(12'h118, 5'd0, 64'h1111_2222_3333_4444, "R6 write ignored");
        // R11 same-cycle accept and status clear
        send(5'd6, 5'h0A, 64'hABCD, 64'h1234);
        reg_wr = 1; reg_addr = 12'h330; reg_wdata = 64'h0;
        cycle();
        peek(12'h330, 5'd0, 64'h0A, "R11 write wins busy");
        peek(12'h130, 5'd0, 64'hABCD, "R11 data stored");
        // random phase
        seed = $urandom(32'd2024);
        for (int n = 0; n < 4000; n++) begin
            int op = int'($urandom % 4);
            int g  = int'($urandom % 6);
            msg_valid = 1'($urandom % 2);
            msg_cpu   = 5'($urandom % 10);
            msg_src   = 5'($urandom);
            msg_d0    = {$urandom, $urandom};
            msg_d1    = {$urandom, $urandom};
            reg_rd    = (op == 1 || op == 3);
            reg_wr    = (op >= 2);
            reg_req_id = 5'($urandom % 10);
            reg_addr  = {1'b0, 3'(g), 5'((g == 4) ? $urandom % 4 : $urandom % 10), 3'($urandom)};
            if ($urandom % 8 == 0) reg_addr = 12'($urandom);
            reg_wdata = {$urandom, $urandom};
            cycle();
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule